// File: doc/BRIEF.md
# Finite-Difference Polynomial Table Generator

This block produces the successive values f(0), f(1), f(2), … of a polynomial of degree at most six using nothing but adders. Software first writes seven seed registers: the starting value f(0) and the starting differences of order one through six. It then issues a start pulse together with an order and a count. The block copies the seeds into a chain of working registers and presents one table value per accepted transfer on a valid/ready output stream. On each transfer every working register takes in the old contents of the register one order above it.

Computing the seed differences from polynomial coefficients is left to software. The order input limits how many difference registers feed the chain. A count of accepted values ends the run, and a done flag then stays up until the next start.

Top module: `poly_diff_gen`

## Requirements
- R1: A start pulse with a nonzero count copies the seed bank into the working registers. From the next cycle on, out_valid is high and out_data shows the seed written at seed_sel 0 (the value f(0)).
- R2: Each accepted transfer (out_valid and out_ready both high) advances the chain, with every register using pre-step values: value += d1 and d_k += d_(k+1). Only orders at or below the latched order take part. With seeds 41/2/2 at order 2 the stream is 41, 43, 47, 53, 61.
- R3: The difference register at the latched order never changes during a run. Seeds at seed_sel indexes above the order have no effect on any output value.
- R4: An order of 0 yields a constant stream equal to f(0). An order of 7 behaves exactly like order 6.
- R5: While out_valid is high and out_ready is low, out_valid stays high and out_data and all working state hold.
- R6: After the count-th accepted transfer, out_valid is low and done is high from the next cycle on. done stays high until the next start, and done and out_valid are never high together.
- R7: A start pulse with count 0 produces no output. It raises done in the next cycle.
- R8: All additions wrap modulo 2^W. From f(0)=0xFFFFFFF0, d1=0x10, d2=1 at order 2 the stream is FFFFFFF0, 00000000, 00000011, 00000023.
- R9: Seed writes during a run do not change that run; they take effect at the next start. A start during a run restarts from the seeds with the new order and count.
- R10: After reset out_valid and done are low and every seed register is zero. seed_sel 7 writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| seed_we | input | 1 | Seed write strobe |
| seed_sel | input | 3 | Seed index: 0 = value, 1..6 = difference order |
| seed_data | input | W | Seed write data, two's complement |
| order | input | 3 | Polynomial order 0..6 (7 acts as 6), latched at start |
| count | input | CNT_W | Number of values to emit, latched at start |
| start | input | 1 | Start pulse: reload seeds and begin a run |
| out_valid | output | 1 | Table value available |
| out_ready | input | 1 | Consumer accepts the value |
| out_data | output | W | Current table value |
| done | output | 1 | Run complete |

## Verification
The bench goes after ordering inside a step. A chain that let a register see an already-updated neighbour would drift from the second value onward, and random order-6 seeds expose that. Random back-pressure catches a design that advances while stalled, because it would skip values. Order masking is probed by loading large seeds above the order: a design that leaks them shows wrong values at once. An order of 7 is compared with order 6. The end of a run is checked at counts of zero and small nonzero values: an off-by-one counter emits one value too many or too few, or leaves done and valid up together. Seed writes during a run and restarts mid-stream catch a design that reads the seed bank live instead of a snapshot.

// File: rtl/pdg_pkg.sv
package pdg_pkg;

  typedef enum logic [1:0] {
    PDG_IDLE = 2'd0,
    PDG_RUN  = 2'd1,
    PDG_DONE = 2'd2
  } pdg_state_e;

endpackage

// File: rtl/pdg_seed_bank.sv
module pdg_seed_bank #(
  parameter int W     = 32,
  parameter int NREG  = 7,
  parameter int SEL_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [SEL_W-1:0]    sel,
  input  logic [W-1:0]        wdata,
  output logic [NREG*W-1:0]   seeds_o
);

  logic [W-1:0] bank_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    logic en;
    assign en = we && (sel == SEL_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_q[g] <= '0;
      end else if (en) begin
        bank_q[g] <= wdata;
      end
    end

    assign seeds_o[g*W +: W] = bank_q[g];
  end

endmodule

// File: rtl/pdg_diff_chain.sv
module pdg_diff_chain #(
  parameter int W       = 32,
  parameter int MAX_ORD = 6,
  parameter int NREG    = MAX_ORD + 1,
  parameter int SEL_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  logic [SEL_W-1:0]   ord_in,
  input  logic [NREG*W-1:0]  seeds_i,
  output logic [W-1:0]       value_o,
  output logic [W-1:0]       d1_o,
  output logic [SEL_W-1:0]   ord_q
);

  logic [SEL_W-1:0] ord_cl;
  logic [W-1:0]     acc_q [NREG];
  logic [W-1:0]     acc_n [NREG];
  logic             acc_en;

  assign ord_cl = (ord_in > SEL_W'(MAX_ORD)) ? SEL_W'(MAX_ORD) : ord_in;
  assign acc_en = load || step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ord_q <= '0;
    end else if (load) begin
      ord_q <= ord_cl;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_stage
    logic [W-1:0] addend;

    if (g < NREG - 1) begin : g_feed
      assign addend = (SEL_W'(g + 1) <= ord_q) ? acc_q[g+1] : '0;
    end else begin : g_top
      assign addend = '0;
    end

    always_comb begin
      if (load) begin
        acc_n[g] = seeds_i[g*W +: W];
      end else begin
        acc_n[g] = acc_q[g] + addend;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q[g] <= '0;
      end else if (acc_en) begin
        acc_q[g] <= acc_n[g];
      end
    end
  end

  assign value_o = acc_q[0];
  assign d1_o    = acc_q[1];

endmodule

// File: rtl/pdg_ctrl.sv
module pdg_ctrl
  import pdg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  input  logic             out_ready,
  output logic             load,
  output logic             step,
  output logic             out_valid,
  output logic             done
);

  pdg_state_e       st_q, st_n;
  logic [CNT_W-1:0] rem_q, rem_n;

  always_comb begin
    st_n  = st_q;
    rem_n = rem_q;
    if (start) begin
      rem_n = count;
      st_n  = (count == '0) ? PDG_DONE : PDG_RUN;
    end else if (st_q == PDG_RUN && out_ready) begin
      rem_n = rem_q - 1'b1;
      if (rem_q == CNT_W'(1)) begin
        st_n = PDG_DONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PDG_IDLE;
      rem_q <= '0;
    end else begin
      st_q  <= st_n;
      rem_q <= rem_n;
    end
  end

  assign out_valid = (st_q == PDG_RUN);
  assign done      = (st_q == PDG_DONE);
  assign load      = start;
  assign step      = out_valid && out_ready && !start;

endmodule

// File: rtl/poly_diff_gen.sv
module poly_diff_gen #(
  parameter  int W       = 32,
  parameter  int MAX_ORD = 6,
  parameter  int CNT_W   = 16,
  localparam int NREG    = MAX_ORD + 1,
  localparam int SEL_W   = $clog2(NREG + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seed_we,
  input  logic [SEL_W-1:0] seed_sel,
  input  logic [W-1:0]     seed_data,
  input  logic [SEL_W-1:0] order,
  input  logic [CNT_W-1:0] count,
  input  logic             start,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_data,
  output logic             done
);

  logic [1:0]        rst_sync_q;
  logic              rst_l;
  logic [NREG*W-1:0] seeds_flat;
  logic              load;
  logic              step;
  logic [W-1:0]      d1;
  logic [SEL_W-1:0]  ord_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_l = rst_sync_q[1];

  pdg_seed_bank #(.W(W), .NREG(NREG), .SEL_W(SEL_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_l),
    .we      (seed_we),
    .sel     (seed_sel),
    .wdata   (seed_data),
    .seeds_o (seeds_flat)
  );

  pdg_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_l),
    .start     (start),
    .count     (count),
    .out_ready (out_ready),
    .load      (load),
    .step      (step),
    .out_valid (out_valid),
    .done      (done)
  );

  pdg_diff_chain #(.W(W), .MAX_ORD(MAX_ORD), .NREG(NREG), .SEL_W(SEL_W)) u_chain (
    .clk     (clk),
    .rst_n   (rst_l),
    .load    (load),
    .step    (step),
    .ord_in  (order),
    .seeds_i (seeds_flat),
    .value_o (out_data),
    .d1_o    (d1),
    .ord_q   (ord_q)
  );

endmodule

// File: rtl/pdg_checker.sv
module pdg_checker #(
  parameter int W     = 32,
  parameter int SEL_W = 3,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [CNT_W-1:0] count,
  input logic             out_valid,
  input logic             out_ready,
  input logic [W-1:0]     out_data,
  input logic             done,
  input logic [W-1:0]     seed0,
  input logic [W-1:0]     d1,
  input logic [SEL_W-1:0] ord_q
);

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    start && count != '0 |=> out_valid && out_data == $past(seed0)); // R1

  AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !start |=>
      out_data == $past(out_data) + (($past(ord_q) != '0) ? $past(d1) : '0)); // R2

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !start |=> out_valid && $stable(out_data)); // R5

  AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid); // R6

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done); // R6

  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    start && count == '0 |=> done && !out_valid); // R7

endmodule

bind poly_diff_gen pdg_checker #(.W(W), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .count     (count),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .done      (done),
  .seed0     (seeds_flat[W-1:0]),
  .d1        (d1),
  .ord_q     (ord_q)
);

// File: tb/tb_poly_diff_gen.sv
module tb_poly_diff_gen;

  localparam int CLK_PERIOD = 10;
  localparam int W     = 32;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             seed_we;
  logic [2:0]       seed_sel;
  logic [W-1:0]     seed_data;
  logic [2:0]       order;
  logic [CNT_W-1:0] count;
  logic             start;
  logic             out_valid;
  logic             out_ready;
  logic [W-1:0]     out_data;
  logic             done;

  int errors = 0;
  int checks = 0;

  logic [W-1:0] bank [7];
  logic [W-1:0] work [7];
  int           mord;

  always #(CLK_PERIOD/2) clk = ~clk;

  poly_diff_gen dut (
    .clk(clk), .rst_n(rst_n), .seed_we(seed_we), .seed_sel(seed_sel),
    .seed_data(seed_data), .order(order), .count(count), .start(start),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .done(done)
  );

  task automatic chk(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int clamp_ord(int o);
    return (o > 6) ? 6 : o;
  endfunction

  task automatic model_step();
    for (int k = 0; k < 6; k++) begin
      if (k + 1 <= mord) work[k] = work[k] + work[k+1];
    end
  endtask

  task automatic wr_seed(int idx, logic [W-1:0] val);
    @(negedge clk);
    seed_we = 1'b1; seed_sel = 3'(idx); seed_data = val;
    @(negedge clk);
    seed_we = 1'b0;
    if (idx < 7) bank[idx] = val;
  endtask

  task automatic kick(int ord, int cnt);
    @(negedge clk);
    out_ready = 1'b0;
    order = 3'(ord); count = CNT_W'(cnt); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 7; k++) work[k] = bank[k];
    mord = clamp_ord(ord);
  endtask

  task automatic stream(int n, int pct, string req, bit end_chk);
    int got = 0;
    while (got < n) begin
      @(negedge clk);
      out_ready = (($urandom % 100) < pct);
      chk(out_valid === 1'b1, req, {31'b0, out_valid}, 32'd1);
      chk(out_data === work[0], req, out_data, work[0]);
      if (out_ready) begin
        model_step();
        got++;
      end
    end
    if (end_chk) begin
      @(negedge clk);
      out_ready = 1'b0;
      chk(out_valid === 1'b0 && done === 1'b1, "R6", {30'b0, out_valid, done}, 32'd1);
    end else begin
      @(negedge clk);
      out_ready = 1'b0;
      chk(out_data === work[0], req, out_data, work[0]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; seed_we = 1'b0; seed_sel = '0; seed_data = '0;
    order = '0; count = '0; start = 1'b0; out_ready = 1'b0;
    for (int k = 0; k < 7; k++) bank[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: reset state and zero seed bank
    chk(out_valid === 1'b0 && done === 1'b0, "R10", {30'b0, out_valid, done}, 32'd0);
    wr_seed(7, 32'hDEAD_BEEF);
    kick(3, 2);
    stream(2, 100, "R10", 1'b1);

    // R2: directed table 41, 43, 47, 53, 61
    wr_seed(0, 32'd41); wr_seed(1, 32'd2); wr_seed(2, 32'd2);
    kick(2, 5);
    begin
      logic [W-1:0] exp_tab [5] = '{32'd41, 32'd43, 32'd47, 32'd53, 32'd61};
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        out_ready = 1'b1;
        chk(out_valid === 1'b1 && out_data === exp_tab[i], "R2", out_data, exp_tab[i]);
      end
      @(negedge clk);
      out_ready = 1'b0;
      chk(out_valid === 1'b0 && done === 1'b1, "R6", {30'b0, out_valid, done}, 32'd1);
    end

    // R1/R5: random order-6 seeds with back-pressure
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < 7; k++) wr_seed(k, $urandom);
      kick(6, 30);
      chk(out_data === bank[0], "R1", out_data, bank[0]);
      stream(30, 60, "R5", 1'b1);
    end

    // R3: seeds above the order have no effect, top difference constant
    for (int k = 0; k < 7; k++) wr_seed(k, (k > 3) ? 32'h7000_0000 + k : $urandom % 1000);
    kick(3, 25);
    stream(25, 70, "R3", 1'b1);

    // R4: order 0 constant, order 7 same as order 6
    for (int k = 0; k < 7; k++) wr_seed(k, $urandom);
    kick(0, 10);
    stream(10, 80, "R4", 1'b1);
    kick(7, 20);
    stream(20, 80, "R4", 1'b1);

    // R8: wraparound
    for (int k = 0; k < 7; k++) wr_seed(k, 32'd0);
    wr_seed(0, 32'hFFFF_FFF0); wr_seed(1, 32'h10); wr_seed(2, 32'h1);
    kick(2, 4);
    begin
      logic [W-1:0] wexp [4] = '{32'hFFFF_FFF0, 32'h0, 32'h11, 32'h23};
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        out_ready = 1'b1;
        chk(out_data === wexp[i], "R8", out_data, wexp[i]);
      end
      @(negedge clk);
      out_ready = 1'b0;
    end

    // R7: zero count
    kick(2, 0);
    chk(out_valid === 1'b0 && done === 1'b1, "R7", {30'b0, out_valid, done}, 32'd1);
    @(negedge clk);
    chk(out_valid === 1'b0 && done === 1'b1, "R7", {30'b0, out_valid, done}, 32'd1);

    // R9: seed write during run does not disturb it, takes effect on restart
    for (int k = 0; k < 7; k++) wr_seed(k, $urandom % 5000);
    kick(4, 10);
    stream(4, 100, "R9", 1'b0);
    begin
      logic [W-1:0] keep0 = bank[0];
      wr_seed(0, 32'd999);
      wr_seed(1, 32'd7);
      stream(6, 100, "R9", 1'b1);
      chk(bank[0] === 32'd999 && keep0 !== 32'd999, "R9", bank[0], 32'd999);
    end
    kick(2, 3);
    chk(out_data === 32'd999, "R9", out_data, 32'd999);
    stream(3, 100, "R9", 1'b1);

    // R9: restart during a run
    kick(5, 8);
    stream(3, 100, "R9", 1'b0);
    kick(1, 2);
    stream(2, 50, "R9", 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule